// File: doc/BRIEF.md
# Repetition-Gated PWM Time Base

This block is the counting core of a PWM timer. A 16-bit counter is stepped by a programmable clock divider. It runs in one of three ways: counting up to a limit and wrapping to zero, counting down from the limit and reloading, or counting up and then down in a triangle. Each wrap at the top is an overflow, and each wrap at the bottom is an underflow.

The period limit, the divider value and a compare value are each held as a preload copy and an active copy. The active copy moves only on an update event. An 8-bit repetition down-counter sits between the wraps and the update event, so an update happens once every N+1 wraps. In triangle mode both turning points count toward that number.

A software strobe forces an update at once. Each update raises a one-cycle pulse and sets a sticky flag, which software clears.

The counter direction is held in a two-state machine, `DIR_UP` and `DIR_DOWN`. In up mode the state is forced to `DIR_UP`, and in down mode it is forced to `DIR_DOWN`. In triangle mode the state changes only at the turning points:
- `DIR_UP` goes to `DIR_DOWN` on an overflow.
- `DIR_DOWN` goes to `DIR_UP` on an underflow.
- A software update returns the state to `DIR_UP`, or to `DIR_DOWN` in down mode.

Top module: `rep_pwm_timebase`

## Requirements
- R1: After reset, `count`, `upd_pulse`, `upd_flag` and `cmp_active` are all 0.
- R2: With active divider value P, the counter steps once every P+1 clock cycles in which `cnt_en` is high. While `cnt_en` is low, `count` holds its value.
- R3: With `mode`=0 (up), the counter steps 0,1,…,L and then wraps to 0. L is the active limit, and the wrap is an overflow.
- R4: With `mode`=1 (down), the counter steps L,L-1,…,0 and then reloads L. The reload is an underflow.
- R5: With `mode`=2 or 3 (triangle), the counter climbs from 0 to L. The step leaving L is an overflow and goes to L-1. The counter then descends to 0, and the step leaving 0 is an underflow and goes to 1.
- R6: With repetition value N, an update event occurs on every (N+1)-th overflow or underflow. Both kinds count in triangle mode. The repetition counter reloads N at each update.
- R7: On an update event, the active limit, the active divider value and `cmp_active` take their preload values. At no other time does `cmp_active` change.
- R8: With `arpe`=1, a new limit written mid-period takes effect only at the next update, so the count first reaches the old limit. With `arpe`=0, the written limit becomes active at the next clock edge.
- R9: `sw_update` causes an update event at the next edge whatever the repetition counter holds. It also reloads the repetition counter and clears the divider. It restarts `count` at 0, or at the new active limit in down mode.
- R10: `upd_flag` is set by every update event and stays set until `flag_clr` is high. When an update and `flag_clr` occur in the same cycle, the set wins.
- R11: `upd_pulse` is high in the cycle that follows the edge at which an update occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| mode | input | 2 | 0 up, 1 down, 2 or 3 triangle |
| arpe | input | 1 | Limit preload enable |
| sw_update | input | 1 | Software update strobe |
| arr_wr | input | 1 | Write strobe for the limit |
| arr_wdata | input | 16 | New limit value |
| psc_wr | input | 1 | Write strobe for the divider value |
| psc_wdata | input | 16 | New divider value |
| rep_wr | input | 1 | Write strobe for the repetition value |
| rep_wdata | input | 8 | New repetition value |
| cmp_wr | input | 1 | Write strobe for the compare value |
| cmp_wdata | input | 16 | New compare value |
| flag_clr | input | 1 | Clears the update flag |
| count | output | 16 | Counter value |
| upd_pulse | output | 1 | One-cycle update pulse |
| upd_flag | output | 1 | Sticky update flag |
| cmp_active | output | 16 | Active compare value |

## Verification
The step properties assume two things about the inputs. The first is that `mode` changes only together with a software update, so the direction state always agrees with the mode. The second is that in triangle mode the limit is never made active below the current count. The bench keeps to both assumptions. Every configuration starts with the counter disabled: the registers are written, then a software update is issued, then the flag is cleared, and only then is `cnt_en` raised. The one test that rewrites the limit mid-run uses up mode.

// File: rtl/rtb_pkg.sv
package rtb_pkg;
    typedef enum logic [1:0] {
        MODE_UP     = 2'd0,
        MODE_DOWN   = 2'd1,
        MODE_CENTER = 2'd2
    } cnt_mode_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_state_e;

    function automatic cnt_mode_e decode_mode(input logic [1:0] raw);
        if (raw[1])      return MODE_CENTER;
        else if (raw[0]) return MODE_DOWN;
        else             return MODE_UP;
    endfunction
endpackage

// File: rtl/rtb_prescaler.sv
module rtb_prescaler #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          restart,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    localparam logic [PW-1:0] ONE = PW'(1);

    logic [PW-1:0] div_q;
    logic          at_end;

    assign at_end = (div_q >= limit);
    assign tick   = run && !restart && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else if (run)     div_q <= at_end ? '0 : div_q + ONE;
    end
endmodule

// File: rtl/rtb_core.sv
module rtb_core
    import rtb_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  cnt_mode_e     mode,
    input  logic [CW-1:0] lim,
    input  logic [CW-1:0] lim_next,
    output logic [CW-1:0] count,
    output logic          wrap
);
    localparam logic [CW-1:0] ONE = CW'(1);

    dir_state_e    state_q, state_d, eff_state;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ovf, unf;

    // Up and down modes pin the direction; triangle mode follows the register.
    always_comb begin
        unique case (mode)
            MODE_UP:     eff_state = DIR_UP;
            MODE_DOWN:   eff_state = DIR_DOWN;
            default:     eff_state = state_q;
        endcase
    end

    // Next-state and next-count logic
    always_comb begin
        state_d = eff_state;
        cnt_d   = cnt_q;
        ovf     = 1'b0;
        unf     = 1'b0;
        if (restart) begin
            if (mode == MODE_DOWN) begin
                state_d = DIR_DOWN;
                cnt_d   = lim_next;
            end else begin
                state_d = DIR_UP;
                cnt_d   = '0;
            end
        end else if (tick) begin
            unique case (eff_state)
                DIR_UP: begin
                    if (cnt_q >= lim) begin
                        ovf = 1'b1;
                        if (mode == MODE_CENTER) begin
                            state_d = DIR_DOWN;
                            cnt_d   = (lim == '0) ? '0 : lim - ONE;
                        end else begin
                            cnt_d   = '0;
                        end
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                DIR_DOWN: begin
                    if (cnt_q == '0) begin
                        unf = 1'b1;
                        if (mode == MODE_CENTER) begin
                            state_d = DIR_UP;
                            cnt_d   = (lim_next == '0) ? '0 : ONE;
                        end else begin
                            cnt_d   = lim_next;
                        end
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
                default: cnt_d = cnt_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIR_UP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign count = cnt_q;
    assign wrap  = ovf | unf;
endmodule

// File: rtl/rtb_repeat.sv
module rtb_repeat #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wrap,
    input  logic          force_upd,
    input  logic [RW-1:0] reload,
    output logic          uev
);
    localparam logic [RW-1:0] ONE = RW'(1);

    logic [RW-1:0] rep_q;
    logic          natural_upd;

    assign natural_upd = wrap && (rep_q == '0);
    assign uev         = force_upd || natural_upd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    rep_q <= '0;
        else if (uev)  rep_q <= reload;
        else if (wrap) rep_q <= rep_q - ONE;
    end
endmodule

// File: rtl/rtb_shadow.sv
module rtb_shadow #(
    parameter int            CW      = 16,
    parameter int            PW      = 16,
    parameter int            RW      = 8,
    parameter logic [CW-1:0] ARR_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arpe,
    input  logic          load,
    input  logic          arr_wr,
    input  logic [CW-1:0] arr_wdata,
    input  logic          psc_wr,
    input  logic [PW-1:0] psc_wdata,
    input  logic          rep_wr,
    input  logic [RW-1:0] rep_wdata,
    input  logic          cmp_wr,
    input  logic [CW-1:0] cmp_wdata,
    output logic [CW-1:0] arr_act,
    output logic [CW-1:0] arr_nxt,
    output logic [PW-1:0] psc_act,
    output logic [RW-1:0] rep_pre,
    output logic [CW-1:0] cmp_act
);
    logic [CW-1:0] arr_pre_q, arr_pre_d, arr_act_q;
    logic [PW-1:0] psc_pre_q, psc_pre_d, psc_act_q;
    logic [CW-1:0] cmp_pre_q, cmp_pre_d, cmp_act_q;
    logic [RW-1:0] rep_pre_q;

    // A write in the same cycle as an update is carried straight through.
    assign arr_pre_d = arr_wr ? arr_wdata : arr_pre_q;
    assign psc_pre_d = psc_wr ? psc_wdata : psc_pre_q;
    assign cmp_pre_d = cmp_wr ? cmp_wdata : cmp_pre_q;

    always_comb begin
        if (load)                arr_nxt = arr_pre_d;
        else if (!arpe && arr_wr) arr_nxt = arr_wdata;
        else                     arr_nxt = arr_act_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arr_pre_q <= ARR_RST;
            arr_act_q <= ARR_RST;
            psc_pre_q <= '0;
            psc_act_q <= '0;
            cmp_pre_q <= '0;
            cmp_act_q <= '0;
            rep_pre_q <= '0;
        end else begin
            arr_pre_q <= arr_pre_d;
            psc_pre_q <= psc_pre_d;
            cmp_pre_q <= cmp_pre_d;
            arr_act_q <= arr_nxt;
            if (rep_wr) rep_pre_q <= rep_wdata;
            if (load) begin
                psc_act_q <= psc_pre_d;
                cmp_act_q <= cmp_pre_d;
            end
        end
    end

    assign arr_act = arr_act_q;
    assign psc_act = psc_act_q;
    assign cmp_act = cmp_act_q;
    assign rep_pre = rep_pre_q;
endmodule

// File: rtl/rep_pwm_timebase.sv
module rep_pwm_timebase
    import rtb_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [1:0]       mode,
    input  logic             arpe,
    input  logic             sw_update,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] arr_wdata,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_wdata,
    input  logic             rep_wr,
    input  logic [REP_W-1:0] rep_wdata,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             upd_pulse,
    output logic             upd_flag,
    output logic [CNT_W-1:0] cmp_active
);
    cnt_mode_e        mode_e;
    logic             tick, wrap, uev;
    logic [CNT_W-1:0] arr_act, arr_nxt;
    logic [PSC_W-1:0] psc_act;
    logic [REP_W-1:0] rep_pre;
    logic             pulse_q, flag_q;

    assign mode_e = decode_mode(mode);

    rtb_shadow #(.CW(CNT_W), .PW(PSC_W), .RW(REP_W)) i_shadow (
        .clk(clk), .rst_n(rst_n), .arpe(arpe), .load(uev),
        .arr_wr(arr_wr), .arr_wdata(arr_wdata),
        .psc_wr(psc_wr), .psc_wdata(psc_wdata),
        .rep_wr(rep_wr), .rep_wdata(rep_wdata),
        .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .arr_act(arr_act), .arr_nxt(arr_nxt), .psc_act(psc_act),
        .rep_pre(rep_pre), .cmp_act(cmp_active)
    );

    rtb_prescaler #(.PW(PSC_W)) i_psc (
        .clk(clk), .rst_n(rst_n), .run(cnt_en), .restart(sw_update),
        .limit(psc_act), .tick(tick)
    );

    rtb_core #(.CW(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sw_update),
        .mode(mode_e), .lim(arr_act), .lim_next(arr_nxt),
        .count(count), .wrap(wrap)
    );

    rtb_repeat #(.RW(REP_W)) i_rep (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .force_upd(sw_update),
        .reload(rep_pre), .uev(uev)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= uev;
            if (uev)           flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
        end
    end

    assign upd_pulse = pulse_q;
    assign upd_flag  = flag_q;
endmodule

// File: rtl/rtb_checker.sv
module rtb_checker #(
    parameter int CW = 16,
    parameter int RW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_en,
    input logic          sw_update,
    input logic          flag_clr,
    input logic [1:0]    mode,
    input logic [CW-1:0] count,
    input logic          upd_pulse,
    input logic          upd_flag,
    input logic [CW-1:0] cmp_active,
    input logic          wrap,
    input logic [RW-1:0] rep_q
);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !cnt_en && !sw_update) |=> (count == $past(count)));

    p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cnt_en && !sw_update && mode == 2'd0) |=>
        ((count == $past(count) + ONE) || (count == $past(count)) || (count == '0)));

    p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cnt_en && !sw_update && mode == 2'd1) |=>
        ((count == $past(count) - ONE) || (count == $past(count)) || ($past(count) == '0)));

    p_tri_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && cnt_en && !sw_update && mode[1]) |=>
        ((count == $past(count) + ONE) || (count == $past(count) - ONE) || (count == $past(count))));

    p_rep_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !sw_update && rep_q != '0) |=> !upd_pulse);

    p_cmp_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && !upd_pulse) |-> $stable(cmp_active));

    p_sw_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_update |=> upd_pulse);

    p_flag_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> upd_flag);

    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !flag_clr) |=> upd_flag);
endmodule

bind rep_pwm_timebase rtb_checker #(.CW(CNT_W), .RW(REP_W)) i_rtb_checker (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .sw_update(sw_update),
    .flag_clr(flag_clr), .mode(mode), .count(count), .upd_pulse(upd_pulse),
    .upd_flag(upd_flag), .cmp_active(cmp_active), .wrap(wrap),
    .rep_q(i_rep.rep_q)
);

// File: tb/test_rep_pwm_timebase.sv
module test_rep_pwm_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        arpe = 1'b1;
    logic        sw_update = 1'b0;
    logic        arr_wr = 1'b0;
    logic [15:0] arr_wdata = '0;
    logic        psc_wr = 1'b0;
    logic [15:0] psc_wdata = '0;
    logic        rep_wr = 1'b0;
    logic [7:0]  rep_wdata = '0;
    logic        cmp_wr = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic        flag_clr = 1'b0;
    logic [15:0] count;
    logic        upd_pulse, upd_flag;
    logic [15:0] cmp_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    rep_pwm_timebase i_rep_pwm_timebase (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode), .arpe(arpe),
        .sw_update(sw_update), .arr_wr(arr_wr), .arr_wdata(arr_wdata),
        .psc_wr(psc_wr), .psc_wdata(psc_wdata), .rep_wr(rep_wr),
        .rep_wdata(rep_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .flag_clr(flag_clr), .count(count), .upd_pulse(upd_pulse),
        .upd_flag(upd_flag), .cmp_active(cmp_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Writes all preloads, forces an update with the counter stopped, clears the flag.
    task automatic setup(input int m, input int ap, input int a, input int p,
                         input int n, input int c);
        cnt_en = 1'b0; mode = 2'(m); arpe = ap[0];
        arr_wr = 1'b1; arr_wdata = 16'(a);
        psc_wr = 1'b1; psc_wdata = 16'(p);
        rep_wr = 1'b1; rep_wdata = 8'(n);
        cmp_wr = 1'b1; cmp_wdata = 16'(c);
        step();
        arr_wr = 1'b0; psc_wr = 1'b0; rep_wr = 1'b0; cmp_wr = 1'b0;
        sw_update = 1'b1;
        step();
        sw_update = 1'b0;
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        step();
        // R1: reset state
        chk("R1 count", count, 0);
        chk("R1 pulse", upd_pulse, 0);
        chk("R1 flag", upd_flag, 0);
        chk("R1 cmp", cmp_active, 0);
        rst_n = 1'b1;
        step();

        // Sweep: R2 R3 R4 R5 R6 R7 R11
        for (int m = 0; m < 3; m++)
          for (int a = 1; a <= 3; a++)
            for (int p = 0; p <= 2; p++)
              for (int n = 0; n <= 2; n++) begin
                int kmax, pulses, cval;
                cval = a * 16 + p * 4 + n + 1;
                setup(m, 1, a, p, n, cval);
                chk("R7 cmp loaded", cmp_active, cval);
                chk("R10 flag cleared", upd_flag, 0);
                kmax = 2 * (p + 1) * (2 * a + 2) * (n + 1);
                pulses = 0;
                cnt_en = 1'b1;
                for (int k = 1; k <= kmax; k++) begin
                    int t, ec, ep, e;
                    bit tk, wr;
                    step();
                    t  = k / (p + 1);
                    tk = (k % (p + 1)) == 0;
                    if (m == 0) begin
                        ec = t % (a + 1);
                        wr = tk && (t % (a + 1) == 0);
                        e  = t / (a + 1);
                    end else if (m == 1) begin
                        ec = a - (t % (a + 1));
                        wr = tk && (t % (a + 1) == 0);
                        e  = t / (a + 1);
                    end else begin
                        int ph;
                        ph = t % (2 * a);
                        ec = (ph <= a) ? ph : 2 * a - ph;
                        wr = tk && (t > 1) && ((t - 1) % a == 0);
                        e  = (t > 0) ? (t - 1) / a : 0;
                    end
                    ep = (wr && (e % (n + 1) == 0)) ? 1 : 0;
                    if (m == 0)      chk("R3 R2 up count", count, ec);
                    else if (m == 1) chk("R4 R2 down count", count, ec);
                    else             chk("R5 R2 triangle count", count, ec);
                    chk("R6 R11 update pulse", upd_pulse, ep);
                    pulses += ep;
                end
                cnt_en = 1'b0;
                chk("R10 flag after run", upd_flag, (pulses > 0) ? 1 : 0);
                chk("R7 cmp unchanged", cmp_active, cval);
              end

        // R2: enable low holds the count
        setup(0, 1, 9, 0, 0, 1);
        cnt_en = 1'b1;
        repeat (3) step();
        cnt_en = 1'b0;
        for (int i = 0; i < 5; i++) begin
            step();
            chk("R2 hold while disabled", count, 3);
        end

        // R8: preload enabled, limit 5 then 2 written at count 2
        setup(0, 1, 5, 0, 0, 1);
        cnt_en = 1'b1;
        step(); step();
        chk("R8 count before write", count, 2);
        arr_wr = 1'b1; arr_wdata = 16'd2;
        step();
        arr_wr = 1'b0;
        chk("R8 k3", count, 3);
        step(); step();
        chk("R8 old limit reached", count, 5);
        step();
        chk("R8 wrap at old limit", count, 0);
        chk("R8 update pulse", upd_pulse, 1);
        step(); step();
        chk("R8 new limit", count, 2);
        step();
        chk("R8 wrap at new limit", count, 0);

        // R8: preload disabled, limit takes effect at once
        setup(0, 0, 5, 0, 0, 1);
        cnt_en = 1'b1;
        step(); step();
        arr_wr = 1'b1; arr_wdata = 16'd2;
        step();
        arr_wr = 1'b0;
        chk("R8 immediate k3", count, 3);
        step();
        chk("R8 immediate wrap", count, 0);
        step(); step();
        chk("R8 immediate top", count, 2);
        step();
        chk("R8 immediate second wrap", count, 0);

        // R7: compare and divider transfer only on update (N=1, limit 3)
        setup(0, 1, 3, 0, 1, 10);
        cnt_en = 1'b1;
        cmp_wr = 1'b1; cmp_wdata = 16'd77; psc_wr = 1'b1; psc_wdata = 16'd1;
        step();
        cmp_wr = 1'b0; psc_wr = 1'b0;
        for (int k = 2; k <= 7; k++) begin
            step();
            chk("R7 cmp held before update", cmp_active, 10);
        end
        step();
        chk("R7 cmp after update", cmp_active, 77);
        chk("R6 pulse on second wrap", upd_pulse, 1);
        step();
        chk("R7 divider slows count", count, 0);
        step();
        chk("R7 divider step", count, 1);

        // R9: software update mid-run, up mode, N=2
        setup(0, 1, 3, 0, 2, 1);
        cnt_en = 1'b1;
        step(); step();
        sw_update = 1'b1;
        step();
        sw_update = 1'b0;
        chk("R9 restart count", count, 0);
        chk("R9 forced pulse", upd_pulse, 1);
        chk("R9 flag set", upd_flag, 1);
        begin
            int seen;
            seen = 0;
            for (int k = 1; k <= 12; k++) begin
                step();
                if (upd_pulse) seen++;
                if (k == 12) chk("R9 R6 update after reload", upd_pulse, 1);
            end
            chk("R9 one update in 12 ticks", seen, 1);
        end

        // R9: down mode restart loads the limit
        setup(1, 1, 6, 0, 0, 1);
        chk("R9 down restart", count, 6);

        // R10: set wins over clear, then clear works
        cnt_en = 1'b0;
        sw_update = 1'b1; flag_clr = 1'b1;
        step();
        sw_update = 1'b0; flag_clr = 1'b0;
        chk("R10 set wins", upd_flag, 1);
        step();
        chk("R11 pulse one cycle", upd_pulse, 0);
        chk("R10 flag sticky", upd_flag, 1);
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        chk("R10 flag cleared", upd_flag, 0);
        step();
        chk("R10 flag stays clear", upd_flag, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule